// File: doc/BRIEF.md
# Serial RC Frame Channel Decoder

This block sits behind a UART receiver. It takes in fixed-length 25-byte remote-control frames, one byte per handshake. It locks onto a frame at its start code and counts bytes up to the closing code. When a frame arrives whole and well formed, the block unpacks sixteen 11-bit proportional channel values that are packed back to back, with no gaps, across 22 payload bytes. It also decodes the flag byte, which carries two single-bit discrete channels, a frame-lost indication and a failsafe indication.

A configurable number of leading channels is scaled to signed Q1.14 fixed point. These words are sent in ascending channel order on a 16-bit valid/ready stream, and the final word is marked as last. Frames with a wrong closing byte are thrown away, and so are frames whose byte flow stalls beyond an idle limit. A saturating counter records each frame rejected for either reason.

Top module: `rcf_decoder`

## Requirements
- R1: A byte is taken on a rising edge when `in_valid` and `in_ready` are both high. While no frame is open, any byte other than 0x0F is dropped with no effect. A 0x0F byte opens a frame, and the frame closes after exactly 25 bytes in total.
- R2: If the 25th byte of a frame is not 0x00, the frame produces no output word, leaves the flag outputs unchanged and increments `err_count`.
- R3: Frame bytes 2 to 23 form a 176-bit field, with the earliest byte most significant and each byte MSB first. Channel k (k = 0 to 15) is bits [175-11k -: 11] of this field.
- R4: The 24th byte sets the flag outputs, and only when the frame is accepted. Bit 0 drives `disc0`, bit 1 drives `disc1`, bit 2 drives `frame_lost` and bit 3 drives `failsafe`.
- R5: An accepted frame produces exactly NUM_OUT words, for channels 0 to NUM_OUT-1 in ascending order. `out_last` is high on the final word only.
- R6: A raw value r maps to the signed word y. If r <= 172, then y = -16384. If r >= 1811, then y = +16384. Otherwise y = floor(((r-172)*1310240 + 32768) / 65536) - 16384.
- R7: Suppose a frame is open and no byte is taken for IDLE_CYC consecutive cycles. The partial frame is then discarded and `err_count` increments. A shorter gap does not disturb the frame.
- R8: `in_ready` stays low while any output word of a frame is pending. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: `err_count` saturates at its all-ones value and changes by no more than +1 per cycle.
- R10: After synchronous reset, `out_valid` is 0, `in_ready` is 1, all flag outputs are 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Decoder can take a byte |
| out_data | output | 16 | Scaled channel word, signed Q1.14 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_last | output | 1 | Final word of the frame |
| disc0 | output | 1 | Discrete channel 0 |
| disc1 | output | 1 | Discrete channel 1 |
| frame_lost | output | 1 | Frame-lost flag |
| failsafe | output | 1 | Failsafe flag |
| err_count | output | ERR_W | Saturating count of rejected frames |

## Verification
The bench builds the decoder with NUM_OUT set to 16. With that setting every packed field is forwarded and checked, including the last channel, whose bits straddle a byte edge. IDLE_CYC is cut to 200 cycles so that both a real timeout and a gap just short of one fit into the run. ERR_W is set to 3, so a handful of bad frames drive the counter to its saturation point.

// File: rtl/rcf_pkg.sv
// Shared constants and types for the serial RC frame decoder.
// Assumes the fixed 25-byte frame with 16 packed 11-bit channels.
package rcf_pkg;
    localparam int FRAME_BYTES   = 25;
    localparam int PAYLOAD_BYTES = 22;
    localparam int CHAN_BITS     = 11;
    localparam int PROP_CHANS    = 16;
    localparam int WORD_BITS     = 16;
    localparam int PAYLOAD_BITS  = PAYLOAD_BYTES * 8;
    localparam int HOLD_BITS     = (FRAME_BYTES - 1) * 8;
    localparam logic [7:0] START_CODE = 8'h0F;
    localparam logic [7:0] STOP_CODE  = 8'h00;
    // Flag byte bit positions
    localparam int FLG_DISC0 = 0;
    localparam int FLG_DISC1 = 1;
    localparam int FLG_LOST  = 2;
    localparam int FLG_FSAFE = 3;

    typedef logic [CHAN_BITS-1:0] chan_t;
    typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/rcf_collector.sv
// Frame collector: hunts for the start code, shifts frame bytes into a
// holding register, checks the closing byte and enforces the idle limit.
// Assumes 'take' is the accepted-byte strobe (valid and ready).
module rcf_collector
    import rcf_pkg::*;
#(
    parameter int IDLE_CYC = 375000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [7:0]              byte_in,
    output logic                    frame_good,
    output logic                    frame_bad,
    output logic                    idle_abort,
    output logic [PAYLOAD_BITS-1:0] payload,
    output logic [7:0]              flag_byte
);
    localparam int CNT_W = $clog2(FRAME_BYTES);
    localparam int TMR_W = $clog2(IDLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_BYTES - 1);
    localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(IDLE_CYC - 1);

    logic [CNT_W-1:0]     cnt_q;
    logic [TMR_W-1:0]     tmr_q;
    logic [HOLD_BITS-1:0] hold_q;
    logic                 open_w;
    logic                 done_w;

    assign open_w     = (cnt_q != '0);
    assign done_w     = take && (cnt_q == LAST_IDX);
    assign frame_good = done_w && (byte_in == STOP_CODE);
    assign frame_bad  = done_w && (byte_in != STOP_CODE);
    assign idle_abort = !take && open_w && (tmr_q == TMR_LIMIT);
    assign payload    = hold_q[HOLD_BITS-9 -: PAYLOAD_BITS];
    assign flag_byte  = hold_q[7:0];

    // Byte position counter: hunt, count, close or abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            if (!open_w) begin
                if (byte_in == START_CODE) cnt_q <= CNT_W'(1);
            end else if (cnt_q == LAST_IDX) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (idle_abort) begin
            cnt_q <= '0;
        end
    end

    // Idle timer: cycles since the last byte of an open frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (take || !open_w || idle_abort) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + TMR_W'(1);
        end
    end

    // Holding shift register for the first 24 bytes of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (take && (open_w || byte_in == START_CODE)) begin
            hold_q <= {hold_q[HOLD_BITS-9:0], byte_in};
        end
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
    p_hunt_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !open_w && byte_in != START_CODE) |=> (cnt_q == '0));
    p_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> (cnt_q == '0));
    p_idle_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_abort |=> (cnt_q == '0 && tmr_q == '0));
endmodule

// File: rtl/rcf_unpack.sv
// Channel unpacker: slices the 176-bit payload into 16 fields of 11 bits,
// earliest bits first. Pure wiring; assumes MSB-first payload order.
module rcf_unpack
    import rcf_pkg::*;
(
    input  logic [PAYLOAD_BITS-1:0]               payload,
    output logic [PROP_CHANS-1:0][CHAN_BITS-1:0]  chans
);
    for (genvar k = 0; k < PROP_CHANS; k++) begin : g_slice
        assign chans[k] = payload[PAYLOAD_BITS-1-CHAN_BITS*k -: CHAN_BITS];
    end
endmodule

// File: rtl/rcf_scaler.sv
// Channel scaler: maps a raw 11-bit value onto signed Q1.14 using a
// constant multiply, rounding shift and offset; saturates at the ends.
// Assumes RAW_MAX > RAW_MIN and MUL chosen as 2*FULL*2^SHIFT/(span).
module rcf_scaler
    import rcf_pkg::*;
#(
    parameter int RAW_MIN = 172,
    parameter int RAW_MAX = 1811,
    parameter int MUL     = 1310240,
    parameter int SHIFT   = 16,
    parameter int FULL    = 16384
) (
    input  chan_t raw,
    output word_t scaled
);
    localparam int PROD_W = 48;
    localparam logic [PROD_W-1:0] ROUND = PROD_W'(1) << (SHIFT - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [17:0]       diff;

    // Multiply, round, shift and offset, with clamping at both ends
    always_comb begin
        prod = PROD_W'(int'(raw) - RAW_MIN) * PROD_W'(MUL);
        quot = (prod + ROUND) >> SHIFT;
        diff = 18'(quot[16:0]) - 18'(FULL);
        if (int'(raw) <= RAW_MIN) begin
            scaled = word_t'(-FULL);
        end else if (int'(raw) >= RAW_MAX) begin
            scaled = word_t'(FULL);
        end else begin
            scaled = diff[WORD_BITS-1:0];
        end
    end

    // Output range guard
    always_comb begin
        a_range_r6: assert ($signed(scaled) >= -FULL && $signed(scaled) <= FULL);
    end
endmodule

// File: rtl/rcf_err_count.sv
// Saturating rejected-frame counter; one bump per strobe, cleared by reset.
module rcf_err_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count rejected frames, holding at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && count != TOP) begin
            count <= count + W'(1);
        end
    end

    p_err_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count));
endmodule

// File: rtl/rcf_decoder.sv
// Top of the serial RC frame decoder. Collects frames, unpacks and scales
// the leading NUM_OUT channels, latches them with the flag byte on an
// accepted frame and streams them out while holding the input off.
// Assumes 1 <= NUM_OUT <= 16 and IDLE_CYC >= 2.
module rcf_decoder
    import rcf_pkg::*;
#(
    parameter int NUM_OUT  = 6,
    parameter int IDLE_CYC = 375000,
    parameter int ERR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [15:0]      out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic             disc0,
    output logic             disc1,
    output logic             frame_lost,
    output logic             failsafe,
    output logic [ERR_W-1:0] err_count
);
    localparam int IDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_OUT - 1);

    logic                                 take;
    logic                                 frame_good;
    logic                                 frame_bad;
    logic                                 idle_abort;
    logic [PAYLOAD_BITS-1:0]              payload;
    logic [7:0]                           flag_byte;
    logic [PROP_CHANS-1:0][CHAN_BITS-1:0] chans;
    logic [NUM_OUT-1:0][WORD_BITS-1:0]    scaled;
    logic [NUM_OUT-1:0][WORD_BITS-1:0]    words_q;
    logic                                 busy_q;
    logic [IDX_W-1:0]                     idx_q;
    logic [3:0]                           flags_q;

    assign in_ready  = !busy_q;
    assign take      = in_valid && in_ready;
    assign out_valid = busy_q;
    assign out_data  = words_q[idx_q];
    assign out_last  = busy_q && (idx_q == LAST_WORD);
    assign disc0      = flags_q[0];
    assign disc1      = flags_q[1];
    assign frame_lost = flags_q[2];
    assign failsafe   = flags_q[3];

    rcf_collector #(.IDLE_CYC(IDLE_CYC)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .byte_in    (in_data),
        .frame_good (frame_good),
        .frame_bad  (frame_bad),
        .idle_abort (idle_abort),
        .payload    (payload),
        .flag_byte  (flag_byte)
    );

    rcf_unpack u_unpack (
        .payload (payload),
        .chans   (chans)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_scale
        rcf_scaler u_scale (
            .raw    (chans[g]),
            .scaled (scaled[g])
        );
    end

    rcf_err_count #(.W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (frame_bad || idle_abort),
        .count (err_count)
    );

    // Latch scaled words and flags on an accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            flags_q <= '0;
        end else if (frame_good) begin
            words_q <= scaled;
            flags_q <= {flag_byte[FLG_FSAFE], flag_byte[FLG_LOST],
                        flag_byte[FLG_DISC1], flag_byte[FLG_DISC0]};
        end
    end

    // Output sequencer: walk the words in ascending order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (frame_good) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && out_ready) begin
            if (idx_q == LAST_WORD) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    p_block_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    p_last_only_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> !out_valid);
    p_bad_no_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> !out_valid);
    p_flags_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_good |=> ($stable(disc0) && $stable(disc1) && $stable(frame_lost) && $stable(failsafe)));
endmodule

// File: tb/rcf_decoder_tb_top.sv
module rcf_decoder_tb_top;
    localparam int N    = 16;
    localparam int IDLE = 200;
    localparam int EW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_last;
    logic          disc0, disc1, frame_lost, failsafe;
    logic [EW-1:0] err_count;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    int   exp_err = 0;
    logic [10:0] fch [16];
    logic [7:0]  fflags;
    logic [7:0]  last_good_flags = 8'h00;

    always #4 clk = ~clk;

    rcf_decoder #(.NUM_OUT(N), .IDLE_CYC(IDLE), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_last(out_last), .disc0(disc0),
        .disc1(disc1), .frame_lost(frame_lost), .failsafe(failsafe),
        .err_count(err_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_scale(input int raw);
        if (raw <= 172) return -16384;
        if (raw >= 1811) return 16384;
        return ((longint'(raw) - 172) * 1310240 + 32768) / 65536 - 16384;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic end_bytes();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] stop, input int gap_at, input int gap_len);
        logic [175:0] p;
        p = '0;
        for (int k = 0; k < 16; k++) p = (p << 11) | 176'(fch[k]);
        send_byte(8'h0F);
        for (int i = 0; i < 22; i++) begin
            send_byte(p[175 - 8*i -: 8]);
            if (i == gap_at) begin
                end_bytes();
                repeat (gap_len) @(negedge clk);
            end
        end
        send_byte(fflags);
        send_byte(stop);
        end_bytes();
    endtask

    task automatic drain_and_check(input string tag);
        logic [15:0] prev;
        bit stalled;
        stalled = 0;
        prev = '0;
        for (int w = 0; w < N; w++) begin
            forever begin
                @(negedge clk);
                if (stalled && out_valid)
                    check(out_data == prev, "R8", {tag, " hold under stall"}, out_data, prev);
                if (out_valid)
                    check(!in_ready, "R8", {tag, " in_ready while pending"}, in_ready, 0);
                out_ready = ($urandom % 4) != 0;
                #1;
                if (out_valid && out_ready) begin
                    check($signed(out_data) == exp_scale(int'(fch[w])), "R6",
                          $sformatf("%s word %0d raw %0d", tag, w, fch[w]),
                          $signed(out_data), exp_scale(int'(fch[w])));
                    check(out_last == (w == N - 1), "R5", {tag, " last marker"},
                          out_last, (w == N - 1));
                    stalled = 0;
                    break;
                end
                stalled = out_valid;
                prev = out_data;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, "R5", {tag, " no extra word"}, out_valid, 0);
        check(in_ready, "R8", {tag, " ready after drain"}, in_ready, 1);
        check({failsafe, frame_lost, disc1, disc0} == fflags[3:0], "R4",
              {tag, " flags"}, {failsafe, frame_lost, disc1, disc0}, fflags[3:0]);
        last_good_flags = fflags;
    endtask

    task automatic rand_frame();
        for (int k = 0; k < 16; k++) begin
            case ($urandom % 4)
                0: fch[k] = 11'($urandom % 2048);
                1: fch[k] = 11'(165 + $urandom % 15);
                2: fch[k] = 11'(1804 + $urandom % 15);
                default: fch[k] = 11'(172 + $urandom % 1640);
            endcase
        end
        fflags = 8'($urandom);
    endtask

    task automatic expect_no_output(input string req, input string tag);
        bit seen;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        check(!seen, req, {tag, " no output"}, seen, 0);
    endtask

    task automatic check_err(input string req, input string tag);
        @(negedge clk);
        check(int'(err_count) == exp_err, req, {tag, " err_count"}, err_count, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7361));
        repeat (5) @(negedge clk);
        // R10 reset state
        check(!out_valid, "R10", "reset out_valid", out_valid, 0);
        check(in_ready, "R10", "reset in_ready", in_ready, 1);
        check(err_count == 0, "R10", "reset err_count", err_count, 0);
        check({failsafe, frame_lost, disc1, disc0} == 0, "R10", "reset flags",
              {failsafe, frame_lost, disc1, disc0}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R6 directed corner values, all bit patterns and clamps
        fch[0] = 11'd172;  fch[1] = 11'd1811; fch[2] = 11'd0;    fch[3] = 11'd2047;
        fch[4] = 11'd991;  fch[5] = 11'd173;  fch[6] = 11'd1810; fch[7] = 11'h555;
        fch[8] = 11'h2AA;  fch[9] = 11'd1;    fch[10] = 11'h400; fch[11] = 11'd171;
        fch[12] = 11'd1812; fch[13] = 11'd1000; fch[14] = 11'd500; fch[15] = 11'h7FE;
        fflags = 8'h05;
        send_frame(8'h00, -1, 0);
        drain_and_check("R3 directed");

        // R1 junk bytes before start are dropped
        send_byte(8'h33); send_byte(8'hF0); send_byte(8'h00); send_byte(8'hFF);
        end_bytes();
        expect_no_output("R1", "junk");
        rand_frame();
        fflags = 8'h0A;
        send_frame(8'h00, -1, 0);
        drain_and_check("R1 after junk");
        check_err("R1", "junk not counted");

        // R2 bad closing byte
        rand_frame();
        fflags = ~last_good_flags;
        send_frame(8'h5A, -1, 0);
        expect_no_output("R2", "bad stop");
        exp_err++;
        check_err("R2", "bad stop");
        check({failsafe, frame_lost, disc1, disc0} == last_good_flags[3:0], "R2",
              "flags kept", {failsafe, frame_lost, disc1, disc0}, last_good_flags[3:0]);

        // R7 idle timeout mid-frame
        send_byte(8'h0F);
        for (int i = 0; i < 9; i++) send_byte(8'($urandom));
        end_bytes();
        repeat (IDLE + 20) @(negedge clk);
        exp_err++;
        check_err("R7", "timeout");
        expect_no_output("R7", "timeout");
        rand_frame();
        send_frame(8'h00, -1, 0);
        drain_and_check("R7 resync");

        // R7 shorter gap keeps the frame
        rand_frame();
        send_frame(8'h00, 11, IDLE / 2);
        drain_and_check("R7 short gap");
        check_err("R7", "short gap");

        // R3 R5 R6 random frames
        for (int f = 0; f < 25; f++) begin
            rand_frame();
            send_frame(8'h00, -1, 0);
            drain_and_check($sformatf("R3 rand %0d", f));
        end

        // R9 saturation
        for (int f = 0; f < 8; f++) begin
            rand_frame();
            send_frame(8'($urandom % 255 + 1), -1, 0);
            if (exp_err < 7) exp_err++;
            check_err("R9", $sformatf("sat step %0d", f));
        end
        rand_frame();
        send_frame(8'h00, -1, 0);
        drain_and_check("R9 after sat");
        check_err("R9", "sat hold");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule